// File: doc/BRIEF.md
# Register Move Sequencer

This block carries out register-to-register copy and register swap instructions for a small 8/16-bit processor datapath. After a one-cycle start request it counts through a fixed run of cycles and steers read selects, write selects and write enables into a register file that it holds itself. The register file keeps the visible registers and one internal scratch register. Instruction fetch, flag updates and memory traffic are outside this block. The first two cycles of every instruction belong to fetch: the sequencer counts them but writes nothing.

Every move is handled as a 16-bit move made of two-cycle steps, so moving a byte register costs as many cycles as moving a word register. In the normal timing a copy passes through the scratch register in 6 cycles and a swap uses 8 cycles. A fast timing removes one step: a copy writes the destination directly in 4 cycles. A swap finishes in 6 cycles because its last two moves share one step on two write ports. A load port and a peek port on the register file let the surrounding datapath preset and observe the visible registers.

Top module: `xfer_seq_top`

## Requirements
- R1: With `busy` low, a high `start` at a rising edge is accepted: `busy` is high from the next cycle on. `op_exg`, `fast`, `sel_a` and `sel_b` are captured at that edge, and later changes to them do not affect the instruction.
- R2: Cycles 1 and 2 after acceptance (fetch) assert no write enable.
- R3: Copy in normal timing (`op_exg`=0, `fast`=0) lasts 6 cycles. At the end of cycle 4 the register coded by `sel_a` is written to scratch. At the end of cycle 6 scratch is written to the register coded by `sel_b`.
- R4: Swap in normal timing (`op_exg`=1, `fast`=0) lasts 8 cycles. Cycle 4 writes `sel_a` to scratch, cycle 6 writes `sel_b` into `sel_a`, and cycle 8 writes scratch into `sel_b`.
- R5: Copy in fast timing lasts 4 cycles. Cycle 4 writes `sel_a` directly into `sel_b`, and scratch is not touched.
- R6: Swap in fast timing lasts 6 cycles. Cycle 4 writes `sel_a` to scratch. Cycle 6 writes `sel_b` into `sel_a` on port 0 (`wr_en[0]`) and scratch into `sel_b` on port 1 (`wr_en[1]`). Both reads use the values from before the edge, and port 1 wins where the two writes overlap.
- R7: The cycle count depends only on the operation and the timing mode, never on whether the registers involved are 8 or 16 bits wide.
- R8: Code 0 is the 16-bit pair whose upper byte is the register of code 8 and whose lower byte is the register of code 9. An 8-bit register (codes 8 to 11) reads as 0xFF in the upper byte. When an 8-bit register is written, it keeps the low byte of the value.
- R9: Codes 1 to 5 are five 16-bit registers. Codes 6, 7 and 12 to 15 name no register: they read as 0xFFFF, and writes to them change nothing.
- R10: Each write enable is high for one cycle only, the second cycle of a two-cycle step. `done` is high only in the final cycle of the instruction, and `busy` is low in the cycle after it.
- R11: A `start` while `busy` is high is ignored: the running instruction keeps its length and its results.
- R12: A synchronous reset leaves `busy`, `done` and `wr_en` low from the next cycle on. It cancels any pending write and clears every register to zero.
- R13: `load_en` writes `load_data` at the next edge into the register coded by `load_sel`, with the width rules of R8 and R9. `peek_data` shows, combinationally, the present value of the register coded by `peek_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, taken only when idle |
| op_exg | input | 1 | 0 = copy, 1 = swap |
| fast | input | 1 | 1 = fast timing |
| sel_a | input | 4 | Copy source / first swap register |
| sel_b | input | 4 | Copy destination / second swap register |
| load_en | input | 1 | Preset write enable |
| load_sel | input | 4 | Preset register code |
| load_data | input | 16 | Preset value |
| peek_sel | input | 4 | Observed register code |
| peek_data | output | 16 | Value of the observed register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| wr_en | output | 2 | Write enables of the two register-file write ports |

## Verification
The properties assume that the preset port is used only while the sequencer is idle, because a preset landing in the middle of a move would spoil the expected register contents. They also assume that reset is held for at least one edge before any check counts. The stimulus raises `load_en` only between instructions, after `busy` has dropped. It applies reset both at time zero and once in the middle of a swap. Start requests during an instruction are issued on purpose and are expected to change nothing.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 4;
    localparam int RSEL_W     = SEL_W + 1;
    localparam int NWIDE      = 5;
    localparam int NNARROW    = 4;
    localparam int CNT_W      = 4;
    localparam int FETCH_CYC  = 2;
    localparam int STEP_CYC   = 2;
    localparam int CODE_PAIR  = 0;
    localparam int CODE_WIDE0 = 1;
    localparam int CODE_NAR0  = 8;
    localparam int HI_W       = DATA_W - BYTE_W;

    localparam logic [RSEL_W-1:0] RS_SCRATCH = {1'b1, {SEL_W{1'b0}}};

    typedef struct packed {
        logic [NWIDE-1:0][DATA_W-1:0]   wide;
        logic [NNARROW-1:0][BYTE_W-1:0] narrow;
        logic [DATA_W-1:0]              scratch;
    } rf_t;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             exg;
        logic             fast;
        logic [SEL_W-1:0] a;
        logic [SEL_W-1:0] b;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] cyc_total(logic exg, logic fast);
        int steps;
        steps = exg ? 3 : 2;
        if (fast) steps = steps - 1;
        return CNT_W'(FETCH_CYC + STEP_CYC * steps);
    endfunction

    function automatic logic [DATA_W-1:0] rf_read(rf_t s, logic [RSEL_W-1:0] sel);
        logic [DATA_W-1:0] r;
        r = '1;
        if (sel[SEL_W]) begin
            r = s.scratch;
        end else if (sel[SEL_W-1:0] == SEL_W'(CODE_PAIR)) begin
            r = {s.narrow[0], s.narrow[1]};
        end else begin
            for (int i = 0; i < NWIDE; i++)
                if (sel[SEL_W-1:0] == SEL_W'(CODE_WIDE0 + i)) r = s.wide[i];
            for (int i = 0; i < NNARROW; i++)
                if (sel[SEL_W-1:0] == SEL_W'(CODE_NAR0 + i)) r = {{HI_W{1'b1}}, s.narrow[i]};
        end
        return r;
    endfunction

    function automatic rf_t rf_write(rf_t s, logic [RSEL_W-1:0] sel, logic [DATA_W-1:0] v);
        rf_t r;
        r = s;
        if (sel[SEL_W]) begin
            r.scratch = v;
        end else if (sel[SEL_W-1:0] == SEL_W'(CODE_PAIR)) begin
            r.narrow[0] = v[DATA_W-1:BYTE_W];
            r.narrow[1] = v[BYTE_W-1:0];
        end else begin
            for (int i = 0; i < NWIDE; i++)
                if (sel[SEL_W-1:0] == SEL_W'(CODE_WIDE0 + i)) r.wide[i] = v;
            for (int i = 0; i < NNARROW; i++)
                if (sel[SEL_W-1:0] == SEL_W'(CODE_NAR0 + i)) r.narrow[i] = v[BYTE_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/xfer_step_ctrl.sv
module xfer_step_ctrl
    import xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_exg,
    input  logic              fast,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    output logic              busy,
    output logic              done,
    output logic [RSEL_W-1:0] rd_sel0,
    output logic [RSEL_W-1:0] wr_sel0,
    output logic              we0,
    output logic [RSEL_W-1:0] rd_sel1,
    output logic [RSEL_W-1:0] wr_sel1,
    output logic              we1
);

    ctrl_t ctl_d, ctl_q;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] step;
    logic             step_end;
    logic [RSEL_W-1:0] ra, rb;

    assign total    = cyc_total(ctl_q.exg, ctl_q.fast);
    assign step     = (ctl_q.cnt + CNT_W'(1)) >> 1;
    assign step_end = ctl_q.busy && !ctl_q.cnt[0];
    assign ra       = {1'b0, ctl_q.a};
    assign rb       = {1'b0, ctl_q.b};

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.busy) begin
            if (ctl_q.cnt == total) begin
                ctl_d.busy = 1'b0;
                ctl_d.cnt  = '0;
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end else if (start) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = CNT_W'(1);
            ctl_d.exg  = op_exg;
            ctl_d.fast = fast;
            ctl_d.a    = sel_a;
            ctl_d.b    = sel_b;
        end
        if (rst) ctl_d = '0;
    end

    always_ff @(posedge clk) ctl_q <= ctl_d;

    always_comb begin
        rd_sel0 = RS_SCRATCH;
        wr_sel0 = RS_SCRATCH;
        rd_sel1 = RS_SCRATCH;
        wr_sel1 = RS_SCRATCH;
        we0     = 1'b0;
        we1     = 1'b0;
        case (step)
            CNT_W'(2): begin
                rd_sel0 = ra;
                wr_sel0 = (ctl_q.fast && !ctl_q.exg) ? rb : RS_SCRATCH;
                we0     = step_end;
            end
            CNT_W'(3): begin
                rd_sel0 = ctl_q.exg ? rb : RS_SCRATCH;
                wr_sel0 = ctl_q.exg ? ra : rb;
                we0     = step_end;
                if (ctl_q.exg && ctl_q.fast) begin
                    rd_sel1 = RS_SCRATCH;
                    wr_sel1 = rb;
                    we1     = step_end;
                end
            end
            CNT_W'(4): begin
                rd_sel0 = RS_SCRATCH;
                wr_sel0 = rb;
                we0     = step_end;
            end
            default: ;
        endcase
    end

    assign busy = ctl_q.busy;
    assign done = ctl_q.busy && (ctl_q.cnt == total);

endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile
    import xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [DATA_W-1:0] load_data,
    input  logic [RSEL_W-1:0] rd_sel0,
    input  logic [RSEL_W-1:0] wr_sel0,
    input  logic              we0,
    input  logic [RSEL_W-1:0] rd_sel1,
    input  logic [RSEL_W-1:0] wr_sel1,
    input  logic              we1,
    input  logic [SEL_W-1:0]  peek_sel,
    output logic [DATA_W-1:0] peek_data
);

    rf_t rf_d, rf_q;
    logic [DATA_W-1:0] val0, val1;

    assign val0 = rf_read(rf_q, rd_sel0);
    assign val1 = rf_read(rf_q, rd_sel1);

    always_comb begin
        rf_d = rf_q;
        if (load_en) rf_d = rf_write(rf_d, {1'b0, load_sel}, load_data);
        if (we0)     rf_d = rf_write(rf_d, wr_sel0, val0);
        if (we1)     rf_d = rf_write(rf_d, wr_sel1, val1);
        if (rst)     rf_d = '0;
    end

    always_ff @(posedge clk) rf_q <= rf_d;

    assign peek_data = rf_read(rf_q, {1'b0, peek_sel});

endmodule

// File: rtl/xfer_seq_top.sv
module xfer_seq_top
    import xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_exg,
    input  logic              fast,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    input  logic              load_en,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [DATA_W-1:0] load_data,
    input  logic [SEL_W-1:0]  peek_sel,
    output logic [DATA_W-1:0] peek_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        wr_en
);

    logic [RSEL_W-1:0] rd_sel0, wr_sel0, rd_sel1, wr_sel1;
    logic              we0, we1;

    xfer_step_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_exg  (op_exg),
        .fast    (fast),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .busy    (busy),
        .done    (done),
        .rd_sel0 (rd_sel0),
        .wr_sel0 (wr_sel0),
        .we0     (we0),
        .rd_sel1 (rd_sel1),
        .wr_sel1 (wr_sel1),
        .we1     (we1)
    );

    xfer_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_sel  (load_sel),
        .load_data (load_data),
        .rd_sel0   (rd_sel0),
        .wr_sel0   (wr_sel0),
        .we0       (we0),
        .rd_sel1   (rd_sel1),
        .wr_sel1   (wr_sel1),
        .we1       (we1),
        .peek_sel  (peek_sel),
        .peek_data (peek_data)
    );

    assign wr_en = {we1, we0};

endmodule

// File: rtl/xfer_seq_checker.sv
module xfer_seq_checker
    import xfer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       op_exg,
    input logic       fast,
    input logic       load_en,
    input logic       busy,
    input logic       done,
    input logic [1:0] wr_en
);

    logic [CNT_W-1:0] age_q;
    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
            len_q <= '0;
        end else begin
            age_q <= busy ? age_q + CNT_W'(1) : '0;
            if (!busy && start) len_q <= cyc_total(op_exg, fast);
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_fetch_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && age_q < CNT_W'(FETCH_CYC)) |-> (wr_en == 2'b00));

    p_port1_with_port0_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en[1] |-> wr_en[0]);

    p_length_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (age_q + CNT_W'(1) == len_q));

    p_we_step_end_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en != 2'b00) |-> age_q[0]);

    p_we_single_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en[0] |=> !wr_en[0]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_busy_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_reset_idle_r12: assert property (@(posedge clk)
        rst |=> (!busy && !done && wr_en == 2'b00));

    p_load_idle_r13: assert property (@(posedge clk) disable iff (rst)
        load_en |-> !busy);

endmodule

bind xfer_seq_top xfer_seq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_exg  (op_exg),
    .fast    (fast),
    .load_en (load_en),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en)
);

// File: tb/xfer_seq_top_test.sv
module xfer_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int SCR = 16;

    logic        clk = 1'b0;
    logic        rst, start, op_exg, fast, load_en;
    logic [3:0]  sel_a, sel_b, load_sel, peek_sel;
    logic [15:0] load_data, peek_data;
    logic        busy, done;
    logic [1:0]  wr_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_seq_top uut (
        .clk(clk), .rst(rst), .start(start), .op_exg(op_exg), .fast(fast),
        .sel_a(sel_a), .sel_b(sel_b), .load_en(load_en), .load_sel(load_sel),
        .load_data(load_data), .peek_sel(peek_sel), .peek_data(peek_data),
        .busy(busy), .done(done), .wr_en(wr_en)
    );

    // behavioural reference
    typedef struct { int cyc; int src; int dst; } move_t;
    move_t       plan_q[$];
    logic [15:0] vals_q[$];
    logic [15:0] m_w [5];
    logic [7:0]  m_n [4];
    logic [15:0] m_t;
    bit          m_busy;
    int          m_cnt, m_len;

    function automatic logic [15:0] mread(int code);
        if (code == SCR) return m_t;
        if (code == 0) return {m_n[0], m_n[1]};
        if (code >= 1 && code <= 5) return m_w[code-1];
        if (code >= 8 && code <= 11) return {8'hFF, m_n[code-8]};
        return 16'hFFFF;
    endfunction

    function automatic void mwrite(int code, logic [15:0] v);
        if (code == SCR) m_t = v;
        else if (code == 0) begin m_n[0] = v[15:8]; m_n[1] = v[7:0]; end
        else if (code >= 1 && code <= 5) m_w[code-1] = v;
        else if (code >= 8 && code <= 11) m_n[code-8] = v[7:0];
    endfunction

    function automatic void mclear();
        foreach (m_w[i]) m_w[i] = '0;
        foreach (m_n[i]) m_n[i] = '0;
        m_t = '0;
        m_busy = 0; m_cnt = 0; m_len = 0;
        plan_q.delete();
    endfunction

    function automatic void plan(int c, int s, int d);
        move_t mv;
        mv.cyc = c; mv.src = s; mv.dst = d;
        plan_q.push_back(mv);
        if (c > m_len) m_len = c;
    endfunction

    function automatic int moves_now();
        int n = 0;
        foreach (plan_q[i]) if (plan_q[i].cyc == m_cnt) n++;
        return n;
    endfunction

    function automatic void model_step();
        if (rst) begin
            mclear();
            return;
        end
        if (load_en) mwrite(int'(load_sel), load_data);
        if (m_busy) begin
            vals_q.delete();
            foreach (plan_q[i]) if (plan_q[i].cyc == m_cnt) vals_q.push_back(mread(plan_q[i].src));
            foreach (plan_q[i]) if (plan_q[i].cyc == m_cnt) mwrite(plan_q[i].dst, vals_q.pop_front());
            if (m_cnt == m_len) begin m_busy = 0; m_cnt = 0; plan_q.delete(); end
            else m_cnt++;
        end else if (start) begin
            m_busy = 1; m_cnt = 1; m_len = 0;
            plan_q.delete();
            if (!op_exg && !fast) begin plan(4, sel_a, SCR); plan(6, SCR, sel_b); end
            else if (op_exg && !fast) begin plan(4, sel_a, SCR); plan(6, sel_b, sel_a); plan(8, SCR, sel_b); end
            else if (!op_exg) plan(4, sel_a, sel_b);
            else begin plan(4, sel_a, SCR); plan(6, sel_b, sel_a); plan(6, SCR, sel_b); end
        end
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, a quarter period after each rising edge
    always @(posedge clk) begin
        int nm;
        model_step();
        nm = m_busy ? moves_now() : 0;
        #(CLK_PERIOD/4);
        check("R1 busy", {15'b0, busy}, {15'b0, m_busy});
        check("R10 done", {15'b0, done}, {15'b0, (m_busy && m_cnt == m_len)});
        check("R2/R10 wr_en", {14'b0, wr_en}, {14'b0, (nm >= 2), (nm >= 1)});
    end

    task automatic check_all(string tag);
        for (int c = 0; c < 16; c++) begin
            peek_sel = 4'(c);
            #1;
            check(tag, peek_data, mread(c));
        end
        @(negedge clk);
    endtask

    task automatic load(int code, logic [15:0] v);
        load_sel = 4'(code); load_data = v; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_op(bit exg, bit fst, int a, int b, string tag, bit poke);
        int n = 0;
        int exp_len;
        exp_len = 2 + 2 * ((exg ? 3 : 2) - (fst ? 1 : 0));
        op_exg = exg; fast = fst; sel_a = 4'(a); sel_b = 4'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: operand inputs changed after acceptance must not matter
        op_exg = ~exg; fast = ~fst; sel_a = 4'(b); sel_b = 4'(a);
        while (busy) begin
            n++;
            if (poke) start = 1'b1;   // R11: requests while busy
            @(negedge clk);
        end
        start = 1'b0;
        check("R7 cycles", 16'(n), 16'(exp_len));
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_exg = 1'b0; fast = 1'b0; load_en = 1'b0;
        sel_a = '0; sel_b = '0; load_sel = '0; load_data = '0; peek_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R12 reset contents");

        load(1, 16'h1234); load(2, 16'h5678); load(3, 16'h9ABC);
        load(4, 16'hDEF0); load(5, 16'h0F1E);
        load(8, 16'hAA11); load(9, 16'h0022); load(10, 16'h0033); load(11, 16'h0044);
        load(7, 16'h7777);
        check_all("R13 preset");

        run_op(0, 0, 1, 2, "R3 copy word", 0);
        run_op(0, 0, 8, 3, "R8 copy byte to word", 0);
        run_op(0, 0, 1, 9, "R8 copy word to byte", 0);
        run_op(0, 0, 0, 4, "R8 copy pair", 0);
        run_op(1, 0, 1, 2, "R4 swap words", 0);
        run_op(1, 0, 8, 5, "R7 swap byte with word", 0);
        run_op(0, 1, 3, 1, "R5 fast copy", 0);
        run_op(1, 1, 2, 4, "R6 fast swap", 0);
        run_op(1, 1, 0, 8, "R6 fast swap overlap", 0);
        run_op(0, 0, 6, 1, "R9 copy from empty code", 0);
        run_op(0, 1, 2, 12, "R9 copy to empty code", 0);
        run_op(1, 0, 1, 3, "R11 start while busy", 1);
        run_op(0, 1, 10, 11, "R5 fast byte copy", 0);

        // R12: reset in the middle of a swap
        op_exg = 1'b1; fast = 1'b0; sel_a = 4'd2; sel_b = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 busy after reset", {15'b0, busy}, 16'h0000);
        check_all("R12 contents after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule